// File: doc/BRIEF.md
# Exclusive Access Monitor

This block is the local reservation tracker for a single processor's load-exclusive and store-exclusive pairs. A load-exclusive arms a reservation and records its address and access size. A later store-exclusive writes memory only when that reservation is still armed and covers the same address and size. The block drives the memory write enable for the store in the same cycle as the request. It reports a pass/fail status one cycle later.

Every store-exclusive consumes the reservation, whether it succeeds or fails. The reservation is also dropped by an explicit clear-exclusive strobe and by exception entry. The pipeline drives one strobe per access. The memory write port takes `wr_en` in place of its own enable for exclusive stores.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is empty. `st_done` and `wr_en` are low, and a store-exclusive issued before any load-exclusive fails.
- R2: A load-exclusive with a size code of 0 (byte), 1 (halfword) or 2 (word) arms the reservation and records `addr` and `size`.
- R3: A store-exclusive whose `addr` and `size` equal the recorded ones, while the reservation is armed, raises `wr_en` in its own cycle. In the following cycle `st_done` is high and `st_fail` is 0.
- R4: A store-exclusive made with no armed reservation, or with a different address or size, keeps `wr_en` low. In the following cycle `st_done` is high and `st_fail` is 1.
- R5: Every store-exclusive empties the reservation, whether it passes or fails, so a repeated identical store-exclusive fails.
- R6: A clear-exclusive strobe empties the reservation.
- R7: Exception entry empties the reservation. A store-exclusive in the same cycle as exception entry fails.
- R8: A load-exclusive made while the reservation is armed replaces the recorded address and size.
- R9: When a clear-exclusive, store-exclusive or exception entry coincides with a load-exclusive, the reservation ends up empty.
- R10: `st_done` is high exactly in the cycle after each store-exclusive and low in every other cycle.
- R11: Size code 3 is reserved. A load-exclusive carrying it leaves the reservation empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_excl | input | 1 | Load-exclusive strobe |
| st_excl | input | 1 | Store-exclusive strobe |
| clr_excl | input | 1 | Clear-exclusive strobe |
| exc_entry | input | 1 | Exception entry pulse |
| addr | input | ADDR_W | Access address |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| wr_en | output | 1 | Gated memory write enable for the store-exclusive |
| st_fail | output | 1 | Store-exclusive status, 0 success, 1 failure |
| st_done | output | 1 | Status valid, one cycle after a store-exclusive |

## Verification
The monitor's internal state consists only of the armed flag and the recorded address and size. Any error in that state appears at the very next store-exclusive, as a wrong `wr_en` in the same cycle and a wrong `st_fail` one cycle later. The bench therefore follows each stimulus with a probing store. A reservation left armed after a store, clear or exception appears as a second store passing. A corrupted address or size appears as an exact match failing, or a near miss passing.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_excl,
  input  logic              st_excl,
  input  logic              clr_excl,
  input  logic              exc_entry,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              wr_en,
  output logic              st_fail,
  output logic              st_done
);
  localparam logic [1:0] SIZE_RSVD = 2'd3;

  logic              armed;
  logic [ADDR_W-1:0] rsv_addr;
  logic [1:0]        rsv_size;
  logic              hit;
  logic              drop;

  assign hit   = armed && (addr == rsv_addr) && (size == rsv_size) && !exc_entry;
  assign wr_en = st_excl && hit;
  assign drop  = st_excl || clr_excl || exc_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      rsv_addr <= '0;
      rsv_size <= '0;
      st_done  <= 1'b0;
      st_fail  <= 1'b0;
    end else begin
      st_done <= st_excl;
      if (st_excl) st_fail <= !hit;
      if (drop)
        armed <= 1'b0;
      else if (ld_excl)
        armed <= (size != SIZE_RSVD);
      if (ld_excl && !drop) begin
        rsv_addr <= addr;
        rsv_size <= size;
      end
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_excl,
  input logic st_excl,
  input logic clr_excl,
  input logic exc_entry,
  input logic wr_en,
  input logic st_fail,
  input logic st_done
);
  // R3
  pass_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (st_done && !st_fail));
  // R4
  fail_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_excl && !wr_en) |=> (st_done && st_fail));
  // R5
  store_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_excl |=> !wr_en);
  // R6
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_excl |=> !wr_en);
  // R7
  exc_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |-> !wr_en);
  // R7
  exc_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !wr_en);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_excl |=> !st_done);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_excl |=> st_done);
  // R1
  we_only_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> st_excl);
endmodule

bind excl_monitor excl_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_excl(ld_excl), .st_excl(st_excl),
  .clr_excl(clr_excl), .exc_entry(exc_entry), .wr_en(wr_en),
  .st_fail(st_fail), .st_done(st_done)
);

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  localparam int AW = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_excl = 0, st_excl = 0, clr_excl = 0, exc_entry = 0;
  logic [AW-1:0] addr = '0;
  logic [1:0] size = '0;
  logic wr_en, st_fail, st_done;
  int total = 0, bad = 0;
  logic we_s, done_s, fail_s;

  always #5 clk = ~clk;

  excl_monitor #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_excl(ld_excl), .st_excl(st_excl),
    .clr_excl(clr_excl), .exc_entry(exc_entry), .addr(addr), .size(size),
    .wr_en(wr_en), .st_fail(st_fail), .st_done(st_done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic s, input logic c, input logic e,
                      input logic [AW-1:0] a, input logic [1:0] z);
    ld_excl = l; st_excl = s; clr_excl = c; exc_entry = e; addr = a; size = z;
    #1 we_s = wr_en;
    @(negedge clk);
    done_s = st_done; fail_s = st_fail;
    ld_excl = 0; st_excl = 0; clr_excl = 0; exc_entry = 0;
  endtask

  task automatic probe(input string req, input logic [AW-1:0] a, input logic [1:0] z,
                       input bit pass);
    step(0, 1, 0, 0, a, z);
    check(req, we_s, pass);
    check(req, done_s, 1);
    check(req, fail_s, !pass);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 check("R1", wr_en, 0);
    check("R1", st_done, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", st_done, 0);
    probe("R1", 0, 2, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R10", done_s, 0);

    // R2 R3 R4 R11 sweep, R5 repeat store
    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 16; b++)
          for (int t = 0; t < 4; t++) begin
            step(1, 0, 0, 0, AW'(a), 2'(s));
            check("R10", done_s, 0);
            probe((s == 3) ? "R11" : "R3/R4", AW'(b), 2'(t), (s != 3) && (a == b) && (s == t));
            probe("R5", AW'(a), 2'(s), 0);
          end

    // R6
    step(1, 0, 0, 0, 5, 2);
    step(0, 0, 1, 0, 0, 0);
    probe("R6", 5, 2, 0);
    // R7 exception between
    step(1, 0, 0, 0, 6, 1);
    step(0, 0, 0, 1, 0, 0);
    probe("R7", 6, 1, 0);
    // R7 exception same cycle as store
    step(1, 0, 0, 0, 7, 0);
    step(0, 1, 0, 1, 7, 0);
    check("R7", we_s, 0);
    check("R7", fail_s, 1);
    // R8 replace
    step(1, 0, 0, 0, 3, 2);
    step(1, 0, 0, 0, 9, 1);
    probe("R8", 3, 2, 0);
    step(1, 0, 0, 0, 3, 2);
    step(1, 0, 0, 0, 9, 1);
    probe("R8", 9, 1, 1);
    // R9 precedence
    step(1, 0, 1, 0, 4, 2);
    probe("R9", 4, 2, 0);
    step(1, 0, 0, 1, 4, 2);
    probe("R9", 4, 2, 0);
    step(1, 1, 0, 0, 4, 2);
    check("R9", we_s, 0);
    probe("R9", 4, 2, 0);
    // R11 reserved after armed
    step(1, 0, 0, 0, 2, 0);
    step(1, 0, 0, 0, 2, 3);
    probe("R11", 2, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule